// File: doc/BRIEF.md
# 720-line raster and scanout generator

This block produces the complete raster for a 1280-wide, 720-line picture at 24 frames per second. It runs from a 29.7 MHz pixel clock, one tenth of a 297 MHz system clock. On every clock it presents three 10-bit channel words for a downstream serializer. During blanking each word is a control token that carries the horizontal and vertical sync bits. During the visible region each word carries one 8-bit colour component, with the two upper bits zero, ready for pixel encoding further down the chain. A separate data-enable output marks the visible region.

Picture data comes from a 16-bit RGB565 framebuffer that holds a 640x350 image. The block fetches it through a simple read port that has a fixed one-clock latency. It shows every source pixel for two clocks to fill the 1280-clock line. It computes each line's base address itself, and returns to the image base after the 350th and the 700th visible line, so the image appears twice down the screen. Vertical framing is 15 top blank lines, 700 visible lines, 30 bottom blank lines and 5 vertical-sync lines.

Two state machines drive the block. The horizontal machine steps H_FRONT → H_SYNC → H_BACK → H_ACTIVE → H_FRONT, and each step is taken on the last clock of the current phase. The vertical machine steps V_TOP → V_ACT → V_BOT → V_SYNC → V_TOP, and each step is taken at the end of the last line of the current phase. All geometry values are parameters, so a reduced raster can be built for test.

Top module: `raster720_gen`

## Requirements
- R1: A line lasts 1650 clocks. In time order it holds 110 blank clocks, then 40 clocks of horizontal sync, then 220 blank clocks, then 1280 active clocks.
- R2: A frame lasts 750 lines. In time order it holds 15 top blank lines, then 700 visible lines, then 30 bottom blank lines, then 5 lines with vertical sync, so vsync rises once every 750 lines.
- R3: While de is low, tmds_ch0 carries the token for {vsync,hsync}. The tokens are: 00 → 10'b1101010100, 01 → 10'b0010101011, 10 → 10'b0101010100, 11 → 10'b1010101011.
- R4: While de is low, tmds_ch1 and tmds_ch2 carry the 00 token outside vertical sync and the 10 token during vertical-sync lines.
- R5: hsync, vsync, de and the three channel words are registered and describe the same raster position. They lag the internal position by one clock. hsync also pulses during vertical-sync lines, and de is high only on active clocks of visible lines.
- R6: fb_rd_req pulses once per two active clocks on visible lines. The first request comes on the last blank clock before the active region. The word returns on fb_rd_data in the next clock. Pixel p of a line is read from byte address line_base + 2p.
- R7: The line base starts at the framebuffer base (default 0x1000) and advances by 1280 bytes per visible line. It returns to the base after the 350th and the 700th visible line of each frame.
- R8: On active clocks, source pixel p fills active clocks 2p and 2p+1. tmds_ch2, tmds_ch1 and tmds_ch0 carry red, green and blue as {2'b00, c, c_msbs}. Red is bits [15:11] and blue is bits [4:0], each widened with its top 3 bits. Green is bits [10:5], widened with its top 2 bits.
- R9: A synchronous reset places the raster at clock 0 of the first top blank line. While reset is held, de, hsync, vsync and fb_rd_req are low and all channels carry the 00 token.
- R10: No read request is issued on top blank, bottom blank or vertical-sync lines.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous reset, active high |
| fb_rd_req | output | 1 | Framebuffer read strobe |
| fb_rd_addr | output | AW | Byte address of the requested pixel |
| fb_rd_data | input | 16 | RGB565 word, valid one clock after the request |
| tmds_ch0 | output | 10 | Blue component or sync-bearing token |
| tmds_ch1 | output | 10 | Green component or token |
| tmds_ch2 | output | 10 | Red component or token |
| de | output | 1 | Active video flag |
| hsync | output | 1 | Horizontal sync, active high |
| vsync | output | 1 | Vertical sync, active high |

## Verification
The hardest events to reach are the two line-base reloads. One falls midway through the visible region and one at the end of a frame, and together with the frame wrap they happen only once per 1.24 million clocks at full geometry. The bench therefore builds the block with a shrunken raster: 24-clock lines, a 3-line image shown over 6 visible lines, and 12 lines per frame. It runs three whole frames, so every reload, the vsync-line token switch and the wrap into the next frame occur several times. A scoreboard, built from the timing rules, predicts every channel word, every read request and its address.

// File: rtl/raster_pkg.sv
package raster_pkg;

    typedef enum logic [1:0] {H_FRONT, H_SYNC, H_BACK, H_ACTIVE} hphase_t;
    typedef enum logic [1:0] {V_TOP, V_ACT, V_BOT, V_SYNC} vphase_t;

    localparam logic [9:0] TOK_00 = 10'b1101010100;
    localparam logic [9:0] TOK_01 = 10'b0010101011;
    localparam logic [9:0] TOK_10 = 10'b0101010100;
    localparam logic [9:0] TOK_11 = 10'b1010101011;

    function automatic logic [9:0] ctl_token(input logic v, input logic h);
        unique case ({v, h})
            2'b00:   return TOK_00;
            2'b01:   return TOK_01;
            2'b10:   return TOK_10;
            default: return TOK_11;
        endcase
    endfunction

endpackage

// File: rtl/raster_htimer.sv
module raster_htimer
    import raster_pkg::*;
#(
    parameter int FRONT  = 110,
    parameter int SYNC   = 40,
    parameter int BACK   = 220,
    parameter int ACTIVE = 1280,
    parameter int CW     = 11
) (
    input  logic          clk,
    input  logic          rst,
    output hphase_t       phase,
    output logic [CW-1:0] pos,
    output logic          line_end
);

    hphase_t       nxt;
    logic [CW-1:0] last_pos;
    logic          at_last;

    always_comb begin
        unique case (phase)
            H_FRONT:  begin last_pos = CW'(FRONT - 1);  nxt = H_SYNC;   end
            H_SYNC:   begin last_pos = CW'(SYNC - 1);   nxt = H_BACK;   end
            H_BACK:   begin last_pos = CW'(BACK - 1);   nxt = H_ACTIVE; end
            H_ACTIVE: begin last_pos = CW'(ACTIVE - 1); nxt = H_FRONT;  end
        endcase
    end

    assign at_last  = (pos == last_pos);
    assign line_end = (phase == H_ACTIVE) && at_last;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= H_FRONT;
            pos   <= '0;
        end else if (at_last) begin
            phase <= nxt;
            pos   <= '0;
        end else begin
            pos   <= pos + 1'b1;
        end
    end

    // R1: sync is entered only from the final front-porch clock
    a_r1_sync_entry: assert property (@(posedge clk) disable iff (rst)
        (phase == H_SYNC && $past(phase) != H_SYNC)
        |-> ($past(phase) == H_FRONT && $past(pos) == CW'(FRONT - 1)));

    // R1: a new line starts only after the full active run
    a_r1_line_wrap: assert property (@(posedge clk) disable iff (rst)
        (phase == H_FRONT && $past(phase) == H_ACTIVE)
        |-> $past(pos) == CW'(ACTIVE - 1));

endmodule

// File: rtl/raster_vseq.sv
module raster_vseq
    import raster_pkg::*;
#(
    parameter int          TOP    = 15,
    parameter int          SRC_H  = 350,
    parameter int          BOT    = 30,
    parameter int          VSYNC  = 5,
    parameter int          LW     = 10,
    parameter int          AW     = 32,
    parameter logic [31:0] BASE   = 32'h1000,
    parameter int          STRIDE = 1280
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          line_end,
    output vphase_t       phase,
    output logic [AW-1:0] line_base
);

    localparam int ACT_LINES = 2 * SRC_H;

    vphase_t       nxt;
    logic [LW-1:0] lcnt;
    logic [LW-1:0] last_line;
    logic [LW-1:0] act_left;
    logic          at_last;
    logic          reload;

    always_comb begin
        unique case (phase)
            V_TOP:  begin last_line = LW'(TOP - 1);       nxt = V_ACT;  end
            V_ACT:  begin last_line = LW'(ACT_LINES - 1); nxt = V_BOT;  end
            V_BOT:  begin last_line = LW'(BOT - 1);       nxt = V_SYNC; end
            V_SYNC: begin last_line = LW'(VSYNC - 1);     nxt = V_TOP;  end
        endcase
    end

    assign at_last = (lcnt == last_line);
    assign reload  = (act_left == LW'(SRC_H + 1)) || (act_left == LW'(1));

    always_ff @(posedge clk) begin
        if (rst) begin
            phase     <= V_TOP;
            lcnt      <= '0;
            act_left  <= LW'(ACT_LINES);
            line_base <= AW'(BASE);
        end else if (line_end) begin
            if (at_last) begin
                phase <= nxt;
                lcnt  <= '0;
            end else begin
                lcnt  <= lcnt + 1'b1;
            end
            if (phase == V_ACT) begin
                act_left  <= act_left - 1'b1;
                line_base <= reload ? AW'(BASE) : line_base + AW'(STRIDE);
            end
            if (phase == V_SYNC && at_last) begin
                act_left <= LW'(ACT_LINES);
            end
        end
    end

    // R2: vertical sync follows the bottom blank lines only
    a_r2_vsync_entry: assert property (@(posedge clk) disable iff (rst)
        (phase == V_SYNC && $past(phase) != V_SYNC) |-> $past(phase) == V_BOT);

    // R7: after the last line of either image copy the base is back at the start
    a_r7_base_reload: assert property (@(posedge clk) disable iff (rst)
        $past(line_end && phase == V_ACT && reload) |-> line_base == AW'(BASE));

endmodule

// File: rtl/raster_out.sv
module raster_out
    import raster_pkg::*;
#(
    parameter int BACK   = 220,
    parameter int ACTIVE = 1280,
    parameter int CW     = 11,
    parameter int AW     = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  hphase_t       hphase,
    input  logic [CW-1:0] hpos,
    input  vphase_t       vphase,
    input  logic [AW-1:0] line_base,
    input  logic [15:0]   rd_data,
    output logic          rd_req,
    output logic [AW-1:0] rd_addr,
    output logic [9:0]    ch0,
    output logic [9:0]    ch1,
    output logic [9:0]    ch2,
    output logic          de,
    output logic          hs,
    output logic          vs
);

    logic       vis, hs_c, vs_c, prefetch, pair_req;
    logic [7:0] red8, grn8, blu8;

    assign vis      = (vphase == V_ACT) && (hphase == H_ACTIVE);
    assign hs_c     = (hphase == H_SYNC);
    assign vs_c     = (vphase == V_SYNC);
    assign prefetch = (vphase == V_ACT) && (hphase == H_BACK) && (hpos == CW'(BACK - 1));
    assign pair_req = vis && hpos[0] && (hpos != CW'(ACTIVE - 1));
    assign rd_req   = prefetch || pair_req;
    assign rd_addr  = line_base + ((hphase == H_ACTIVE) ? AW'(hpos) + AW'(1) : AW'(0));

    assign red8 = {rd_data[15:11], rd_data[15:13]};
    assign grn8 = {rd_data[10:5],  rd_data[10:9]};
    assign blu8 = {rd_data[4:0],   rd_data[4:2]};

    always_ff @(posedge clk) begin
        if (rst) begin
            de  <= 1'b0;
            hs  <= 1'b0;
            vs  <= 1'b0;
            ch0 <= TOK_00;
            ch1 <= TOK_00;
            ch2 <= TOK_00;
        end else begin
            de <= vis;
            hs <= hs_c;
            vs <= vs_c;
            if (vis) begin
                if (!hpos[0]) begin
                    ch0 <= {2'b00, blu8};
                    ch1 <= {2'b00, grn8};
                    ch2 <= {2'b00, red8};
                end
            end else begin
                ch0 <= ctl_token(vs_c, hs_c);
                ch1 <= ctl_token(vs_c, 1'b0);
                ch2 <= ctl_token(vs_c, 1'b0);
            end
        end
    end

    // R6: requests never come on two adjacent clocks
    a_r6_req_spacing: assert property (@(posedge clk) disable iff (rst)
        rd_req |=> !rd_req);

    // R3: blank clocks put the sync-bearing token on channel 0
    a_r3_ch0_token: assert property (@(posedge clk) disable iff (rst)
        !de |-> ch0 == ctl_token(vs, hs));

    // R5: active video never overlaps either sync
    a_r5_de_clean: assert property (@(posedge clk) disable iff (rst)
        de |-> (!hs && !vs));

endmodule

// File: rtl/raster720_gen.sv
module raster720_gen
    import raster_pkg::*;
#(
    parameter int          H_FRONT_CLK = 110,
    parameter int          H_SYNC_CLK  = 40,
    parameter int          H_BACK_CLK  = 220,
    parameter int          SRC_W       = 640,
    parameter int          V_TOP_LN    = 15,
    parameter int          SRC_H       = 350,
    parameter int          V_BOT_LN    = 30,
    parameter int          V_SYNC_LN   = 5,
    parameter int          AW          = 32,
    parameter logic [31:0] FB_BASE     = 32'h1000
) (
    input  logic          clk,
    input  logic          rst,
    output logic          fb_rd_req,
    output logic [AW-1:0] fb_rd_addr,
    input  logic [15:0]   fb_rd_data,
    output logic [9:0]    tmds_ch0,
    output logic [9:0]    tmds_ch1,
    output logic [9:0]    tmds_ch2,
    output logic          de,
    output logic          hsync,
    output logic          vsync
);

    localparam int ACT_CLK = 2 * SRC_W;
    localparam int H_TOTAL = H_FRONT_CLK + H_SYNC_CLK + H_BACK_CLK + ACT_CLK;
    localparam int V_TOTAL = V_TOP_LN + 2 * SRC_H + V_BOT_LN + V_SYNC_LN;
    localparam int HCW     = $clog2(H_TOTAL);
    localparam int LCW     = $clog2(V_TOTAL + 1);
    localparam int STRIDE  = 2 * SRC_W;

    hphase_t        hphase;
    vphase_t        vphase;
    logic [HCW-1:0] hpos;
    logic           line_end;
    logic [AW-1:0]  line_base;

    raster_htimer #(
        .FRONT(H_FRONT_CLK), .SYNC(H_SYNC_CLK), .BACK(H_BACK_CLK),
        .ACTIVE(ACT_CLK), .CW(HCW)
    ) u_htimer (
        .clk(clk), .rst(rst), .phase(hphase), .pos(hpos), .line_end(line_end)
    );

    raster_vseq #(
        .TOP(V_TOP_LN), .SRC_H(SRC_H), .BOT(V_BOT_LN), .VSYNC(V_SYNC_LN),
        .LW(LCW), .AW(AW), .BASE(FB_BASE), .STRIDE(STRIDE)
    ) u_vseq (
        .clk(clk), .rst(rst), .line_end(line_end), .phase(vphase), .line_base(line_base)
    );

    raster_out #(
        .BACK(H_BACK_CLK), .ACTIVE(ACT_CLK), .CW(HCW), .AW(AW)
    ) u_out (
        .clk(clk), .rst(rst), .hphase(hphase), .hpos(hpos), .vphase(vphase),
        .line_base(line_base), .rd_data(fb_rd_data), .rd_req(fb_rd_req),
        .rd_addr(fb_rd_addr), .ch0(tmds_ch0), .ch1(tmds_ch1), .ch2(tmds_ch2),
        .de(de), .hs(hsync), .vs(vsync)
    );

    // R10: reads are confined to visible lines
    a_r10_req_visible: assert property (@(posedge clk) disable iff (rst)
        fb_rd_req |-> vphase == V_ACT);

endmodule

// File: tb/sim_raster720_gen.sv
module sim_raster720_gen;

    localparam int HF = 5, HS = 3, HB = 4, SW = 6;
    localparam int VT = 2, SH = 3, VB = 2, VSN = 2;
    localparam logic [31:0] BASE = 32'h1000;
    localparam int ACT = 2 * SW, LINE = HF + HS + HB + ACT, ALN = 2 * SH;
    localparam int NLINES = VT + ALN + VB + VSN, STRIDE = 2 * SW, FRAMES = 3;
    localparam int ST = HF + HS + HB;

    logic        clk = 1'b0, rst = 1'b1;
    logic        rd_req;
    logic [31:0] rd_addr;
    logic [15:0] rd_data = 16'h0;
    logic [9:0]  c0, c1, c2;
    logic        de, hs, vs;

    raster720_gen #(
        .H_FRONT_CLK(HF), .H_SYNC_CLK(HS), .H_BACK_CLK(HB), .SRC_W(SW),
        .V_TOP_LN(VT), .SRC_H(SH), .V_BOT_LN(VB), .V_SYNC_LN(VSN),
        .AW(32), .FB_BASE(BASE)
    ) u0 (
        .clk(clk), .rst(rst), .fb_rd_req(rd_req), .fb_rd_addr(rd_addr),
        .fb_rd_data(rd_data), .tmds_ch0(c0), .tmds_ch1(c1), .tmds_ch2(c2),
        .de(de), .hsync(hs), .vsync(vs)
    );

    typedef struct packed {logic de; logic hs; logic vs; logic [9:0] c0; logic [9:0] c1; logic [9:0] c2;} out_t;
    typedef struct packed {logic req; logic [31:0] addr; logic vis_line;} req_t;

    out_t q_out[$];
    req_t q_req[$];
    int   checks = 0, fails = 0;
    bit   done = 1'b0;

    initial forever #2 clk = ~clk;

    function automatic logic [9:0] tok(input logic v, input logic h);
        case ({v, h})
            2'b00:   return 10'b1101010100;
            2'b01:   return 10'b0010101011;
            2'b10:   return 10'b0101010100;
            default: return 10'b1010101011;
        endcase
    endfunction

    function automatic logic [15:0] mem_word(input logic [31:0] a);
        logic [15:0] m;
        m = 16'(a[15:0] * 16'd40503);
        return m ^ {a[7:0], a[15:8]};
    endfunction

    task automatic push_frames(input int n);
        for (int f = 0; f < n; f++)
            for (int ln = 0; ln < NLINES; ln++)
                for (int h = 0; h < LINE; h++) begin
                    out_t o; req_t r; logic [15:0] w;
                    bit vl, vsy, hsy, ina; int a, ap, row;
                    vl  = (ln >= VT) && (ln < VT + ALN);
                    vsy = (ln >= VT + ALN + VB);
                    hsy = (h >= HF) && (h < HF + HS);
                    ina = (h >= ST);
                    a   = ln - VT;
                    ap  = h - ST;
                    row = vl ? (a % SH) : 0;
                    o.de = vl && ina; o.hs = hsy; o.vs = vsy;
                    if (o.de) begin
                        w = mem_word(BASE + 32'(row * STRIDE + 2 * (ap / 2)));
                        o.c0 = {2'b00, w[4:0], w[4:2]};
                        o.c1 = {2'b00, w[10:5], w[10:9]};
                        o.c2 = {2'b00, w[15:11], w[15:13]};
                    end else begin
                        o.c0 = tok(vsy, hsy);
                        o.c1 = tok(vsy, 1'b0);
                        o.c2 = tok(vsy, 1'b0);
                    end
                    r.vis_line = vl;
                    r.req  = vl && ((h == ST - 1) || (ina && (ap % 2 == 1) && ap != ACT - 1));
                    r.addr = BASE + 32'(row * STRIDE + (ina ? ap + 1 : 0));
                    q_out.push_back(o);
                    q_req.push_back(r);
                end
    endtask

    task automatic cmp_req(input req_t e);
        checks++;
        if (rd_req !== e.req) begin
            fails++;
            $display("FAIL %s req: actual %0b expected %0b", e.vis_line ? "R6" : "R10", rd_req, e.req);
        end else if (e.req && rd_addr !== e.addr) begin
            fails++;
            $display("FAIL R7 addr: actual %h expected %h", rd_addr, e.addr);
        end
    endtask

    task automatic cmp_out(input out_t e);
        checks++;
        if ({de, hs, vs} !== {e.de, e.hs, e.vs}) begin
            fails++;
            $display("FAIL R5 de/hs/vs: actual %b expected %b", {de, hs, vs}, {e.de, e.hs, e.vs});
        end else if (e.de && {c2, c1, c0} !== {e.c2, e.c1, e.c0}) begin
            fails++;
            $display("FAIL R8 pixel: actual %h expected %h", {c2, c1, c0}, {e.c2, e.c1, e.c0});
        end else if (!e.de && c0 !== e.c0) begin
            fails++;
            $display("FAIL R3 ch0 token: actual %b expected %b", c0, e.c0);
        end else if (!e.de && {c2, c1} !== {e.c2, e.c1}) begin
            fails++;
            $display("FAIL R4 ch1/ch2 tokens: actual %b expected %b", {c2, c1}, {e.c2, e.c1});
        end
    endtask

    // one-clock-latency framebuffer model
    initial begin
        logic pend; logic [31:0] pa;
        forever begin
            @(negedge clk);
            pend = rd_req && !rst;
            pa   = rd_addr;
            @(posedge clk);
            #1;
            if (pend) rd_data = mem_word(pa);
        end
    end

    initial begin
        int cyc = 0, last_h = -1, last_v = -1;
        logic ph = 1'b0, pv = 1'b0;
        push_frames(FRAMES);
        repeat (3) @(posedge clk);
        @(negedge clk);
        checks++;  // R9 reset state
        if ({de, hs, vs, rd_req} !== 4'b0000 || {c0, c1, c2} !== {3{10'b1101010100}}) begin
            fails++;
            $display("FAIL R9 reset: actual %b %h expected 0000 %h", {de, hs, vs, rd_req},
                     {c0, c1, c2}, {3{10'b1101010100}});
        end
        rst = 1'b0;
        cmp_req(q_req.pop_front());
        while (q_out.size() > 0) begin
            @(negedge clk);
            cyc++;
            cmp_out(q_out.pop_front());
            if (q_req.size() > 0) cmp_req(q_req.pop_front());
            if (hs && !ph) begin
                if (last_h >= 0) begin
                    checks++;  // R1 line period
                    if (cyc - last_h != LINE) begin
                        fails++;
                        $display("FAIL R1 line period: actual %0d expected %0d", cyc - last_h, LINE);
                    end
                end
                last_h = cyc;
            end
            if (vs && !pv) begin
                if (last_v >= 0) begin
                    checks++;  // R2 frame period
                    if (cyc - last_v != LINE * NLINES) begin
                        fails++;
                        $display("FAIL R2 frame period: actual %0d expected %0d", cyc - last_v, LINE * NLINES);
                    end
                end
                last_v = cyc;
            end
            ph = hs;
            pv = vs;
        end
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        #(4 * 200000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule